// File: doc/BRIEF.md
# Serial-Memory Read Port Sequencer

This block sequences the read side of a serial field memory with a 12-bit data path. On every rising edge of the read clock it samples three control inputs: a restart request, a read-enable and an output-enable. From them it keeps the word address that the memory array presents. It also drives the enable for the tri-state output bus, and it raises a busy flag while a block jump is in progress.

In normal use, a rising restart request rewinds the pointer to the lowest word address, which is 12. Each clock edge with read-enable high then moves it forward by one word. A random block jump has its own sequence. A fixed read-enable/output-enable handshake follows the rewind. Then a 13-bit block number is shifted in serially on the output-enable line. A fixed latency follows, and after it the pointer lands on the first word of that block. A block number above the valid range stalls the port until the next restart.

Top module: `rdport_seq`

## Requirements
- R1: After synchronous reset, rd_addr_o is 12, q_drive_o is 0 and busy_o is 0.
- R2: A low-to-high change of restart_i, seen on an edge with rd_en_i high, loads rd_addr_o with 12 on that edge. If rd_en_i is low on that edge, the load waits for the first later edge with rd_en_i high, even if restart_i has fallen by then.
- R3: In normal operation, rd_addr_o increases by one on each edge with rd_en_i high and holds on each edge with rd_en_i low. out_en_i has no effect on it.
- R4: In normal operation, q_drive_o after an edge equals the out_en_i value sampled on that edge.
- R5: The block jump is armed only when the four edges after a rewind edge carry this pattern: rd_en_i=1 and out_en_i=0 on edges 1 and 2, then rd_en_i=0 and out_en_i=1 on edges 3 and 4. On the first edge that breaks the pattern, the port acts as in normal operation and stays normal. Edges 1 and 2 advance the pointer as normal reads.
- R6: On edges 5 to 17 the block number is taken from out_en_i, most significant bit first. busy_o is 1 from edge 4 of the pattern until the jump ends. rd_addr_o is frozen throughout and rd_en_i is ignored.
- R7: Along a pattern that still matches, q_drive_o is 0 after every edge from the 3rd through the 17th, whatever out_en_i is.
- R8: On the 20th edge after edge 17 (edge 37), rd_addr_o becomes 12 + 40 × block, busy_o falls and normal operation resumes. During those 20 edges q_drive_o follows out_en_i.
- R9: A block number above 6143 makes the port stall from edge 17. busy_o stays 1, q_drive_o stays 0 and rd_addr_o stays frozen until a restart request arrives. The restart request clears the stall.
- R10: A low-to-high change of restart_i at any point in the jump sequence abandons the jump on that edge, with busy_o low after it. The rewind of R2 then follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| restart_i | input | 1 | Restart request; acts on its low-to-high change |
| rd_en_i | input | 1 | Read enable; advances the pointer |
| out_en_i | input | 1 | Output enable; also the serial block-number input |
| rd_addr_o | output | 18 | Current word address for the array |
| q_drive_o | output | 1 | Drive enable for the tri-state 12-bit data bus |
| busy_o | output | 1 | High during block-number entry, latency and stall |

## Verification
The bench covers a restart raised while read-enable is low. A design that rewinds at once, or loses the pending request, would be off from 12 on the later edges. It covers the edge-3 break in the handshake, where a design that stays in the jump would freeze the pointer and float the bus. It also covers the block numbers 0, 6143 and 6144. Here an off-by-one range check would either stall on the last valid block or jump past the end. Last, it covers a restart in the middle of the serial bits and checks the landing word on exactly the 20th latency edge, so that a miscounted shift or latency shows up as a wrong address or a late busy fall.

// File: rtl/rdport_pkg.sv
package rdport_pkg;
  typedef enum logic [2:0] {
    ST_NORM,
    ST_ENTRY,
    ST_ADDR,
    ST_LAT,
    ST_LOCK
  } rd_state_e;
endpackage

// File: rtl/rdport_restart.sv
module rdport_restart (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  input  logic rd_en_i,
  output logic req_o,
  output logic go_o
);
  logic lvl_q;
  logic pend_q;

  assign req_o = (restart_i & ~lvl_q) | pend_q;
  assign go_o  = req_o & rd_en_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      lvl_q  <= restart_i;
      pend_q <= req_o & ~rd_en_i;
    end
  end

  // R2: a request seen with read-enable low stays pending
  a_r2_pend_wait: assert property (@(posedge clk) disable iff (rst)
    (req_o && !rd_en_i) |=> req_o);
endmodule

// File: rtl/rdport_ctrl.sv
module rdport_ctrl
  import rdport_pkg::*;
#(
  parameter int BLK_W   = 13,
  parameter int BLK_MAX = 6143,
  parameter int LAT_CYC = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic             go_i,
  input  logic             rd_en_i,
  input  logic             out_en_i,
  output rd_state_e        state_o,
  output logic             inc_o,
  output logic             ld_base_o,
  output logic             ld_blk_o,
  output logic [BLK_W-1:0] blk_o,
  output logic             drive_o,
  output logic             busy_o
);
  localparam int PAT_LEN = 4;
  localparam int TOP_A   = (LAT_CYC > BLK_W) ? LAT_CYC : BLK_W;
  localparam int CNT_TOP = (TOP_A > PAT_LEN) ? TOP_A : PAT_LEN;
  localparam int CNT_W   = $clog2(CNT_TOP + 1);

  rd_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BLK_W-1:0] sh_q, sh_d, sh_in;
  logic             drv_q, drv_d;
  logic             busy_q, busy_d;
  logic             pat_first, pat_ok;

  assign sh_in     = {sh_q[BLK_W-2:0], out_en_i};
  assign pat_first = (cnt_q < CNT_W'(2));
  assign pat_ok    = pat_first ? (rd_en_i & ~out_en_i) : (~rd_en_i & out_en_i);

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    drv_d     = drv_q;
    busy_d    = busy_q;
    inc_o     = 1'b0;
    ld_base_o = 1'b0;
    ld_blk_o  = 1'b0;
    if (req_i) begin
      drv_d  = out_en_i;
      busy_d = 1'b0;
      cnt_d  = '0;
      if (go_i) begin
        st_d      = ST_ENTRY;
        ld_base_o = 1'b1;
      end else begin
        st_d = ST_NORM;
      end
    end else begin
      case (st_q)
        ST_NORM: begin
          inc_o = rd_en_i;
          drv_d = out_en_i;
        end
        ST_ENTRY: begin
          if (!pat_ok) begin
            st_d  = ST_NORM;
            inc_o = rd_en_i;
            drv_d = out_en_i;
          end else begin
            inc_o = pat_first;
            drv_d = 1'b0;
            if (cnt_q == CNT_W'(PAT_LEN - 1)) begin
              st_d   = ST_ADDR;
              cnt_d  = '0;
              busy_d = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_ADDR: begin
          sh_d  = sh_in;
          drv_d = 1'b0;
          if (cnt_q == CNT_W'(BLK_W - 1)) begin
            cnt_d = '0;
            st_d  = (sh_in > BLK_W'(BLK_MAX)) ? ST_LOCK : ST_LAT;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_LAT: begin
          drv_d = out_en_i;
          if (cnt_q == CNT_W'(LAT_CYC - 1)) begin
            ld_blk_o = 1'b1;
            st_d     = ST_NORM;
            busy_d   = 1'b0;
            cnt_d    = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_LOCK: begin
          drv_d = 1'b0;
        end
        default: begin
          st_d = ST_NORM;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_NORM;
      cnt_q  <= '0;
      sh_q   <= '0;
      drv_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      drv_q  <= drv_d;
      busy_q <= busy_d;
    end
  end

  assign state_o = st_q;
  assign blk_o   = sh_q;
  assign drive_o = drv_q;
  assign busy_o  = busy_q;

  // R7: bus floats after each serial-bit edge
  a_r7_float_bits: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ADDR) |=> !drv_q);
  // R6: busy stays up in entry, latency and stall
  a_r6_busy_held: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ADDR || st_q == ST_LAT || st_q == ST_LOCK) |-> busy_q);
  // R10: a restart request always drops busy
  a_r10_cancel: assert property (@(posedge clk) disable iff (rst)
    req_i |=> !busy_q);
endmodule

// File: rtl/rdport_ptr.sv
module rdport_ptr #(
  parameter int ADDR_W    = 18,
  parameter int BLK_W     = 13,
  parameter int BASE_ADDR = 12,
  parameter int BLK_WORDS = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_base_i,
  input  logic              ld_blk_i,
  input  logic              inc_i,
  input  logic [BLK_W-1:0]  blk_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] start;

  assign start = ADDR_W'(BASE_ADDR) + ADDR_W'(blk_i) * ADDR_W'(BLK_WORDS);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_o <= ADDR_W'(BASE_ADDR);
    end else if (ld_base_i) begin
      ptr_o <= ADDR_W'(BASE_ADDR);
    end else if (ld_blk_i) begin
      ptr_o <= start;
    end else if (inc_i) begin
      ptr_o <= ptr_o + 1'b1;
    end
  end
endmodule

// File: rtl/rdport_seq.sv
module rdport_seq
  import rdport_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int BLK_W     = 13,
  parameter int BASE_ADDR = 12,
  parameter int BLK_WORDS = 40,
  parameter int BLK_MAX   = 6143,
  parameter int LAT_CYC   = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart_i,
  input  logic              rd_en_i,
  input  logic              out_en_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              q_drive_o,
  output logic              busy_o
);
  logic             req, go, inc, ld_base, ld_blk;
  logic [BLK_W-1:0] blk;
  rd_state_e        st;

  rdport_restart u_restart (
    .clk       (clk),
    .rst       (rst),
    .restart_i (restart_i),
    .rd_en_i   (rd_en_i),
    .req_o     (req),
    .go_o      (go)
  );

  rdport_ctrl #(
    .BLK_W   (BLK_W),
    .BLK_MAX (BLK_MAX),
    .LAT_CYC (LAT_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_i     (req),
    .go_i      (go),
    .rd_en_i   (rd_en_i),
    .out_en_i  (out_en_i),
    .state_o   (st),
    .inc_o     (inc),
    .ld_base_o (ld_base),
    .ld_blk_o  (ld_blk),
    .blk_o     (blk),
    .drive_o   (q_drive_o),
    .busy_o    (busy_o)
  );

  rdport_ptr #(
    .ADDR_W    (ADDR_W),
    .BLK_W     (BLK_W),
    .BASE_ADDR (BASE_ADDR),
    .BLK_WORDS (BLK_WORDS)
  ) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .ld_base_i (ld_base),
    .ld_blk_i  (ld_blk),
    .inc_i     (inc),
    .blk_i     (blk),
    .ptr_o     (rd_addr_o)
  );

  // R2: an accepted restart lands on the lowest word
  a_r2_rewind: assert property (@(posedge clk) disable iff (rst)
    go |=> rd_addr_o == ADDR_W'(BASE_ADDR));
  // R3: normal read with enable low holds the pointer
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (st == ST_NORM && !req && !rd_en_i) |=> $stable(rd_addr_o));
  // R3: normal read with enable high steps the pointer
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (st == ST_NORM && !req && rd_en_i) |=> rd_addr_o == ADDR_W'($past(rd_addr_o) + 1'b1));
  // R9: the stall freezes everything until a restart
  a_r9_stall: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOCK && !req) |=> (busy_o && !q_drive_o && $stable(rd_addr_o)));
  // R6: pointer frozen while bits are shifted in
  a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ADDR && !req) |=> $stable(rd_addr_o));
endmodule

// File: tb/tb_rdport_seq.sv
module tb_rdport_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AMASK = (1 << 18) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rstr = 1'b0, re = 1'b0, oe = 1'b0;
  logic [17:0] addr;
  logic        drive, busy;
  wire  [11:0] q_bus;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // reference model state
  int  m_ptr = 12, m_phase = 0, m_n = 0, m_blk = 0, m_lat = 0;
  bit  m_drv = 0, m_busy = 0, m_prev = 0, m_pend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdport_seq dut (
    .clk       (clk),
    .rst       (rst),
    .restart_i (rstr),
    .rd_en_i   (re),
    .out_en_i  (oe),
    .rd_addr_o (addr),
    .q_drive_o (drive),
    .busy_o    (busy)
  );

  function automatic logic [11:0] word_at(int a);
    return 12'((a * 7 + 3) ^ (a >> 5));
  endfunction

  // stand-in for the array: word indexed by address, tri-state bus
  assign q_bus = drive ? word_at(int'(addr)) : 12'bz;

  task automatic check(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
    end
  endtask

  // behavioural model: phase 0 normal, 1 handshake, 2 bits, 3 latency, 4 stall
  always @(posedge clk) begin
    if (rst) begin
      m_ptr = 12; m_phase = 0; m_drv = 0; m_busy = 0; m_prev = 0; m_pend = 0;
    end else begin
      bit req;
      req = (rstr && !m_prev) || m_pend;
      m_prev = rstr;
      if (req) begin
        m_drv = oe; m_busy = 0; m_phase = 0;
        if (re) begin m_ptr = 12; m_pend = 0; m_phase = 1; m_n = 0; end
        else m_pend = 1;
      end else begin
        case (m_phase)
          0: begin if (re) m_ptr = (m_ptr + 1) & AMASK; m_drv = oe; end
          1: begin
            bit ok;
            m_n++;
            ok = (m_n <= 2) ? (re && !oe) : (!re && oe);
            if (!ok) begin
              m_phase = 0; if (re) m_ptr = (m_ptr + 1) & AMASK; m_drv = oe;
            end else begin
              if (m_n <= 2) m_ptr = (m_ptr + 1) & AMASK;
              m_drv = 0;
              if (m_n == 4) begin m_phase = 2; m_blk = 0; m_busy = 1; end
            end
          end
          2: begin
            m_n++; m_blk = m_blk * 2 + int'(oe); m_drv = 0;
            if (m_n == 17) begin m_phase = (m_blk > 6143) ? 4 : 3; m_lat = 0; end
          end
          3: begin
            m_lat++; m_drv = oe;
            if (m_lat == 20) begin m_ptr = 12 + 40 * m_blk; m_phase = 0; m_busy = 0; end
          end
          default: m_drv = 0;
        endcase
      end
    end
  end

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check({tag, " addr"}, int'(addr), m_ptr);
      check({tag, " drive"}, int'(drive), int'(m_drv));
      check({tag, " busy"}, int'(busy), int'(m_busy));
      if (m_drv) check({tag, " bus"}, int'(q_bus), int'(word_at(m_ptr)));
      else begin
        checks++;
        if (q_bus !== 12'bz) begin
          errors++;
          $display("FAIL %s bus: actual %h expected zzz", tag, q_bus);
        end
      end
    end
  end

  task automatic cyc(input logic r, input logic e, input logic o);
    rstr = r; re = e; oe = o;
    @(negedge clk);
  endtask

  task automatic handshake();
    cyc(0, 1, 1);
    cyc(1, 1, 1);
    cyc(0, 1, 0);
    cyc(0, 1, 0);
    cyc(0, 0, 1);
    check("R7 float after edge 3", int'(drive), 0);
    cyc(0, 0, 1);
    check("R6 busy after edge 4", int'(busy), 1);
  endtask

  task automatic bits(input int blk, input int n);
    for (int i = 12; i > 12 - n; i--) cyc(0, i[0], blk[i]);
  endtask

  task automatic jump(input int blk);
    tag = "R5";
    handshake();
    tag = "R6";
    bits(blk, 13);
    check("R6 pointer frozen", int'(addr), 14);
    tag = "R8";
    for (int i = 0; i < 19; i++) cyc(0, i[1], 0);
    check("R8 busy before edge 37", int'(busy), 1);
    cyc(0, 0, 0);
    check("R8 landing word", int'(addr), 12 + 40 * blk);
    check("R8 busy cleared", int'(busy), 0);
    tag = "R3";
    cyc(0, 1, 1); cyc(0, 1, 0); cyc(0, 1, 1);
    check("R3 reads after jump", int'(addr), 15 + 40 * blk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 addr", int'(addr), 12);
    check("R1 drive", int'(drive), 0);
    check("R1 busy", int'(busy), 0);
    rst = 1'b0;
    tag = "R2";
    cyc(1, 1, 1);
    check("R2 rewind", int'(addr), 12);
    tag = "R3";
    cyc(0, 1, 1); cyc(0, 1, 1); cyc(0, 1, 1);
    check("R3 three reads", int'(addr), 15);
    check("R4 drive high", int'(drive), 1);
    cyc(0, 0, 1); cyc(0, 0, 1);
    check("R3 hold", int'(addr), 15);
    cyc(0, 1, 0);
    check("R3 advance with output off", int'(addr), 16);
    check("R4 drive low", int'(drive), 0);
    tag = "R2";
    cyc(1, 0, 1);
    check("R2 postponed", int'(addr), 16);
    cyc(0, 0, 0);
    check("R2 still waiting", int'(addr), 16);
    cyc(0, 1, 1);
    check("R2 late rewind", int'(addr), 12);
    cyc(0, 1, 1);
    jump(5);
    jump(0);
    jump(6143);
    tag = "R9";
    handshake();
    bits(6144, 13);
    for (int i = 0; i < 6; i++) cyc(0, 1, 1);
    check("R9 stall addr", int'(addr), 14);
    check("R9 stall busy", int'(busy), 1);
    check("R9 stall drive", int'(drive), 0);
    cyc(1, 1, 1);
    check("R9 cleared addr", int'(addr), 12);
    check("R9 cleared busy", int'(busy), 0);
    tag = "R5";
    cyc(0, 1, 1); cyc(1, 1, 1); cyc(0, 1, 0); cyc(0, 1, 0);
    cyc(0, 1, 1);
    check("R5 broken pattern advances", int'(addr), 15);
    check("R5 broken pattern drives", int'(drive), 1);
    cyc(0, 0, 1);
    check("R5 stays normal", int'(busy), 0);
    tag = "R10";
    handshake();
    bits(300, 6);
    cyc(1, 0, 0);
    check("R10 cancel busy", int'(busy), 0);
    cyc(0, 1, 1);
    check("R10 rewind after cancel", int'(addr), 12);
    cyc(0, 1, 1);
    check("R10 normal afterwards", int'(addr), 13);
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule